// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each line holds an address-space identifier, a 20-bit virtual page number, a 20-bit physical frame number and three permission bits. A lookup presents an identifier and a 32-bit virtual address. In the same cycle the block answers hit or miss, the physical address and the permissions. Pages are 4 KB, so the low 12 address bits pass through unchanged.

A missing translation raises one outstanding fill request, which carries the identifier and the page number. An external page walker answers on the fill port, and the block installs the entry there. Software-style maintenance uses a 32-bit flush command word. The command can drop every line, or only the lines in one 4 MB section or one 16 KB group, and it can also be limited to a single identifier.

A static configuration word sets three things: whether lookups continue while a fill is outstanding, which replacement policy is used, and how many lines are in use.

Top module: `asid_tlb`

## Requirements
- R1: After reset no line is valid, `fill_req_valid` is 0, `lk_stall` is 0 and every served lookup reports a miss.
- R2: A served lookup whose identifier and address bits [31:12] match a valid active line asserts `lk_hit` in the same cycle. `lk_paddr` is {frame, vaddr[11:0]} and `lk_perm` is the stored permissions. Identical page numbers under different identifiers do not match.
- R3: A served lookup that misses while no request is outstanding asserts `lk_miss`. From the next cycle, `fill_req_valid` is 1 with that identifier and page number, and it holds until a cycle with `fill_valid`. It is 0 in the cycle after that, and the filled translation then hits.
- R4: With configuration bit 29 clear, `lk_stall` is 1 while a request is outstanding, and lookups report neither hit nor miss.
- R5: With configuration bit 29 set, lookups are served while a request is outstanding. Hits are reported. Further misses assert `lk_miss` but leave the outstanding request unchanged.
- R6: Flush command bits [1:0] select the address match. 0 matches every line. 2 matches lines whose page bits [19:10] equal command bits [19:10] (a 4 MB section). 3 matches lines whose page bits [19:2] equal command bits [19:2] (a 16 KB group). 1 flushes nothing.
- R7: When command bit 31 is set, only lines whose identifier equals the command's identifier field are flushed. That field is bits [30:24] with 128 identifiers and bits [30:29] with 4 identifiers.
- R8: A flush changes the contents at the clock edge of the command write. A lookup in the write cycle itself still sees the contents from before the flush.
- R9: Configuration bits [3:0] (for 8 lines) give the active-line count, and values above the line count are clamped to it. Lines at or above the count are cleared, never hit and are never filled. A count of 0 drops every fill.
- R10: With configuration bit 28 clear, a fill goes to the lowest-numbered invalid active line, or to line 0 when all active lines are valid.
- R11: With configuration bit 28 set, fills go to a pointer that starts at line 0 and advances by one per fill. The pointer wraps to 0 at the active-line count, whether or not the target line is valid.
- R12: A fill whose identifier and page number are already present in an active line overwrites that line instead of taking a victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Bit 29 serve-during-miss, bit 28 round-robin, low bits active-line count |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup served and hit |
| lk_miss | output | 1 | Lookup served and missed |
| lk_stall | output | 1 | Lookups are held off |
| lk_paddr | output | 32 | Translated physical address (0 when no hit) |
| lk_perm | output | 3 | Stored permissions of the hitting line |
| fill_req_valid | output | 1 | A fill request is outstanding |
| fill_req_asid | output | ASID_W | Identifier of the outstanding request |
| fill_req_vpn | output | 20 | Page number of the outstanding request |
| fill_valid | input | 1 | Install an entry this cycle |
| fill_asid | input | ASID_W | Identifier of the entry |
| fill_vpn | input | 20 | Virtual page number of the entry |
| fill_pfn | input | 20 | Physical frame number of the entry |
| fill_perm | input | 3 | Permissions of the entry |
| flush_wr | input | 1 | Flush command write strobe |
| flush_cmd | input | 32 | Flush command word |

## Verification
A table of six translations is installed and then probed with lookups that differ in identifier, in page number and in page offset. These probes separate tag matching from offset pass-through, and show that the identifier takes part in the tag. Flush commands are then issued against a set of lines that share a group, share only a section, or differ only by identifier. Each flush kind and the identifier qualifier therefore removes a different subset, and the reserved type removes nothing. Replacement is tested by punching a hole into a full set of three lines and filling again: the first-invalid policy fills the hole, while the round-robin pointer overwrites line 0. Duplicate fills, shrinking and zero active-line counts, the command-write-cycle lookup and the 2-bit identifier field of a 4-identifier instance each get directed sequences.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SH    = 12;
  localparam int VPN_W      = VA_W - PAGE_SH;
  localparam int PFN_W      = 20;
  localparam int ASID_MAX_W = 7;
  localparam int PERM_W     = 3;
  localparam int SEC_LSB    = 22 - PAGE_SH;
  localparam int GRP_LSB    = 14 - PAGE_SH;
  localparam int CFG_HUM    = 29;
  localparam int CFG_RR     = 28;

  typedef struct packed {
    logic [ASID_MAX_W-1:0] asid;
    logic [VPN_W-1:0]      vpn;
    logic [PFN_W-1:0]      pfn;
    logic [PERM_W-1:0]     perm;
  } tlb_entry_t;

  typedef struct packed {
    logic                  en;
    logic                  any_va;
    logic                  sec;
    logic                  grp;
    logic                  asid_q;
    logic [ASID_MAX_W-1:0] asid;
    logic [VPN_W-1:0]      vpn;
  } flush_t;
endpackage

// File: rtl/tlbx_flush_dec.sv
module tlbx_flush_dec import tlbx_pkg::*; #(
  parameter int ASID_W = 7
) (
  input  logic        flush_wr,
  input  logic [31:0] cmd,
  output flush_t      fl
);
  logic [ASID_W-1:0] asid_raw;
  logic              unused_cmd;

  generate
    if (ASID_W <= 2) begin : g_narrow
      assign asid_raw = cmd[29 +: ASID_W];
    end else begin : g_wide
      assign asid_raw = cmd[24 +: ASID_W];
    end
  endgenerate

  assign unused_cmd = ^cmd[30:20];

  always_comb begin
    fl                  = '0;
    fl.en               = flush_wr && (cmd[1:0] != 2'b01);
    fl.any_va           = (cmd[1:0] == 2'b00);
    fl.sec              = (cmd[1:0] == 2'b10);
    fl.grp              = (cmd[1:0] == 2'b11);
    fl.asid_q           = cmd[31];
    fl.asid[ASID_W-1:0] = asid_raw;
    fl.vpn              = cmd[VPN_W-1:0];
  end
endmodule

// File: rtl/tlbx_line.sv
module tlbx_line import tlbx_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic [ASID_MAX_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]      lk_vpn,
  input  flush_t                fl,
  input  logic                  fill_we,
  input  tlb_entry_t            fill_ent,
  output logic                  lk_match,
  output logic                  valid_o,
  output tlb_entry_t            ent_o
);
  logic       valid_q, valid_d;
  logic       va_ok, asid_ok, kill;
  tlb_entry_t ent_q;
  logic       unused_fl;

  assign unused_fl = ^fl.vpn[GRP_LSB-1:0];

  always_comb begin
    va_ok   = fl.any_va
            | (fl.sec & (ent_q.vpn[VPN_W-1:SEC_LSB] == fl.vpn[VPN_W-1:SEC_LSB]))
            | (fl.grp & (ent_q.vpn[VPN_W-1:GRP_LSB] == fl.vpn[VPN_W-1:GRP_LSB]));
    asid_ok = !fl.asid_q | (ent_q.asid == fl.asid);
    kill    = fl.en & va_ok & asid_ok;
    valid_d = valid_q;
    if (kill)    valid_d = 1'b0;
    if (fill_we) valid_d = 1'b1;
    if (!active) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ent_q <= '0;
    else if (fill_we) ent_q <= fill_ent;
  end

  assign lk_match = active && valid_q && (ent_q.asid == lk_asid) && (ent_q.vpn == lk_vpn);
  assign valid_o  = valid_q;
  assign ent_o    = ent_q;

  // R6
  flush_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !fill_we) |=> !valid_q);

  // R9
  inactive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !valid_q);
endmodule

// File: rtl/tlbx_victim.sv
module tlbx_victim #(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] valid_vec,
  input  logic [CNT_W-1:0] active_cnt,
  input  logic             rr_mode,
  input  logic             fill_fire,
  output logic [IDX_W-1:0] victim,
  output logic             can_fill
);
  logic [IDX_W-1:0] rr_q, rr_d, first_inv;
  logic [CNT_W-1:0] rr_next;

  always_comb begin
    first_inv = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < active_cnt) && !valid_vec[i]) first_inv = IDX_W'(i);
    end
  end

  always_comb begin
    rr_next = CNT_W'(rr_q) + CNT_W'(1);
    rr_d    = rr_q;
    if (fill_fire && rr_mode) rr_d = (rr_next >= active_cnt) ? '0 : IDX_W'(rr_next);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  assign can_fill = (active_cnt != '0);
  assign victim   = rr_mode ? ((CNT_W'(rr_q) < active_cnt) ? rr_q : '0) : first_inv;

  // R11
  victim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    can_fill |-> (CNT_W'(victim) < active_cnt));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb import tlbx_pkg::*; #(
  parameter int LINES      = 8,
  parameter int ASID_COUNT = 128,
  localparam int ASID_W = $clog2(ASID_COUNT),
  localparam int IDX_W  = $clog2(LINES),
  localparam int CNT_W  = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [31:0]       lk_vaddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_stall,
  output logic [31:0]       lk_paddr,
  output logic [2:0]        lk_perm,
  output logic              fill_req_valid,
  output logic [ASID_W-1:0] fill_req_asid,
  output logic [19:0]       fill_req_vpn,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [19:0]       fill_vpn,
  input  logic [19:0]       fill_pfn,
  input  logic [2:0]        fill_perm,
  input  logic              flush_wr,
  input  logic [31:0]       flush_cmd
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // configuration
  logic             hum_en, rr_mode, unused_cfg;
  logic [CNT_W-1:0] cnt_field, active_cnt;

  assign hum_en     = cfg_word[CFG_HUM];
  assign rr_mode    = cfg_word[CFG_RR];
  assign cnt_field  = cfg_word[CNT_W-1:0];
  assign active_cnt = (cnt_field > CNT_W'(LINES)) ? CNT_W'(LINES) : cnt_field;
  assign unused_cfg = ^{cfg_word[31:30], cfg_word[27:CNT_W]};

  // operand widening
  logic [ASID_MAX_W-1:0] lk_asid_x, fill_asid_x;
  tlb_entry_t            fill_ent;

  always_comb begin
    lk_asid_x                = '0;
    lk_asid_x[ASID_W-1:0]    = lk_asid;
    fill_asid_x              = '0;
    fill_asid_x[ASID_W-1:0]  = fill_asid;
    fill_ent                 = '{asid: fill_asid_x, vpn: fill_vpn, pfn: fill_pfn, perm: fill_perm};
  end

  // flush command decode
  flush_t fl;

  tlbx_flush_dec #(.ASID_W(ASID_W)) u_flush_dec (
    .flush_wr (flush_wr),
    .cmd      (flush_cmd),
    .fl       (fl)
  );

  // line array
  logic [LINES-1:0] line_active, hit_vec, valid_vec, dup_vec, fill_we;
  tlb_entry_t       ents [LINES];
  logic [IDX_W-1:0] victim, fill_line, dup_idx;
  logic             can_fill, fill_fire, dup_any;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      assign line_active[g] = (CNT_W'(g) < active_cnt);
      assign dup_vec[g]     = line_active[g] && valid_vec[g]
                              && (ents[g].asid == fill_asid_x) && (ents[g].vpn == fill_vpn);
      assign fill_we[g]     = fill_fire && (fill_line == IDX_W'(g));

      tlbx_line u_line (
        .clk      (clk),
        .rst_n    (rst_i_n),
        .active   (line_active[g]),
        .lk_asid  (lk_asid_x),
        .lk_vpn   (lk_vaddr[31:PAGE_SH]),
        .fl       (fl),
        .fill_we  (fill_we[g]),
        .fill_ent (fill_ent),
        .lk_match (hit_vec[g]),
        .valid_o  (valid_vec[g]),
        .ent_o    (ents[g])
      );
    end
  endgenerate

  tlbx_victim #(.LINES(LINES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .valid_vec  (valid_vec),
    .active_cnt (active_cnt),
    .rr_mode    (rr_mode),
    .fill_fire  (fill_fire),
    .victim     (victim),
    .can_fill   (can_fill)
  );

  always_comb begin
    dup_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (dup_vec[i]) dup_idx = IDX_W'(i);
    end
  end

  assign dup_any   = |dup_vec;
  assign fill_fire = fill_valid && can_fill;
  assign fill_line = dup_any ? dup_idx : victim;

  // lookup result select
  tlb_entry_t hit_ent;
  logic       served, hit_any;

  always_comb begin
    hit_ent = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) hit_ent = hit_ent | ents[i];
    end
  end

  // miss tracking: next state
  logic              pend_q, pend_d;
  logic [ASID_W-1:0] req_asid_q, req_asid_d;
  logic [VPN_W-1:0]  req_vpn_q, req_vpn_d;
  logic              req_cap;

  assign lk_stall = pend_q && !hum_en;
  assign served   = lk_valid && !lk_stall;
  assign hit_any  = |hit_vec;
  assign lk_hit   = served && hit_any;
  assign lk_miss  = served && !hit_any;
  assign lk_paddr = lk_hit ? {hit_ent.pfn, lk_vaddr[PAGE_SH-1:0]} : '0;
  assign lk_perm  = lk_hit ? hit_ent.perm : '0;
  assign req_cap  = lk_miss && !pend_q;

  always_comb begin
    pend_d     = pend_q;
    req_asid_d = req_asid_q;
    req_vpn_d  = req_vpn_q;
    if (fill_valid) pend_d = 1'b0;
    if (req_cap) begin
      pend_d     = 1'b1;
      req_asid_d = lk_asid;
      req_vpn_d  = lk_vaddr[31:PAGE_SH];
    end
  end

  // miss tracking: registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pend_q     <= 1'b0;
      req_asid_q <= '0;
      req_vpn_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (req_cap) begin
        req_asid_q <= req_asid_d;
        req_vpn_q  <= req_vpn_d;
      end
    end
  end

  assign fill_req_valid = pend_q;
  assign fill_req_asid  = req_asid_q;
  assign fill_req_vpn   = req_vpn_q;

  // R2
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(hit_vec));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fill_req_valid && !fill_valid) |=> (fill_req_valid && $stable(fill_req_vpn) && $stable(fill_req_asid)));

  // R3
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fill_req_valid && fill_valid) |=> !fill_req_valid);

  // R4
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    lk_stall |-> (!lk_hit && !lk_miss));
endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        lk_valid;
  logic [6:0]  lk_asid;
  logic [31:0] lk_vaddr;
  logic        lk_hit, lk_miss, lk_stall;
  logic [31:0] lk_paddr;
  logic [2:0]  lk_perm;
  logic        fill_req_valid;
  logic [6:0]  fill_req_asid;
  logic [19:0] fill_req_vpn;
  logic        fill_valid;
  logic [6:0]  fill_asid;
  logic [19:0] fill_vpn, fill_pfn;
  logic [2:0]  fill_perm;
  logic        flush_wr;
  logic [31:0] flush_cmd;

  // second instance with four identifiers
  logic        b_lk_valid;
  logic [1:0]  b_lk_asid;
  logic [31:0] b_lk_vaddr;
  logic        b_lk_hit, b_lk_miss, b_lk_stall;
  logic [31:0] b_lk_paddr;
  logic [2:0]  b_lk_perm;
  logic        b_req_valid;
  logic [1:0]  b_req_asid;
  logic [19:0] b_req_vpn;
  logic        b_fill_valid;
  logic [1:0]  b_fill_asid;
  logic [19:0] b_fill_vpn, b_fill_pfn;
  logic [2:0]  b_fill_perm;
  logic        b_flush_wr;
  logic [31:0] b_flush_cmd;

  int n_tests = 0;
  int n_fail  = 0;
  logic        p_hit, p_miss, p_stall;
  logic [31:0] p_pa;
  logic [2:0]  p_perm;

  always #5 clk = ~clk;

  asid_tlb #(.LINES(8), .ASID_COUNT(128)) i_asid_tlb (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_stall(lk_stall),
    .lk_paddr(lk_paddr), .lk_perm(lk_perm),
    .fill_req_valid(fill_req_valid), .fill_req_asid(fill_req_asid), .fill_req_vpn(fill_req_vpn),
    .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .flush_wr(flush_wr), .flush_cmd(flush_cmd)
  );

  asid_tlb #(.LINES(8), .ASID_COUNT(4)) i_asid_tlb_a4 (
    .clk(clk), .rst_n(rst_n), .cfg_word(32'h2000_0008),
    .lk_valid(b_lk_valid), .lk_asid(b_lk_asid), .lk_vaddr(b_lk_vaddr),
    .lk_hit(b_lk_hit), .lk_miss(b_lk_miss), .lk_stall(b_lk_stall),
    .lk_paddr(b_lk_paddr), .lk_perm(b_lk_perm),
    .fill_req_valid(b_req_valid), .fill_req_asid(b_req_asid), .fill_req_vpn(b_req_vpn),
    .fill_valid(b_fill_valid), .fill_asid(b_fill_asid), .fill_vpn(b_fill_vpn),
    .fill_pfn(b_fill_pfn), .fill_perm(b_fill_perm),
    .flush_wr(b_flush_wr), .flush_cmd(b_flush_cmd)
  );

  // {asid, vpn, pfn, perm}
  localparam logic [49:0] FILLS [6] = '{
    {7'd1,   20'h00010, 20'hA0010, 3'b101},
    {7'd1,   20'h00011, 20'hA0011, 3'b111},
    {7'd2,   20'h00010, 20'hB0010, 3'b001},
    {7'd127, 20'hFFFFF, 20'h12345, 3'b110},
    {7'd0,   20'h00000, 20'h00001, 3'b100},
    {7'd9,   20'h7ABCD, 20'hCAFE0, 3'b011}
  };

  // {asid, vaddr, hit, paddr, perm}
  localparam logic [74:0] LOOKS [8] = '{
    {7'd1,   32'h0001_0ABC, 1'b1, 32'hA001_0ABC, 3'b101},
    {7'd1,   32'h0001_1000, 1'b1, 32'hA001_1000, 3'b111},
    {7'd2,   32'h0001_0FFF, 1'b1, 32'hB001_0FFF, 3'b001},
    {7'd3,   32'h0001_0000, 1'b0, 32'h0000_0000, 3'b000},
    {7'd127, 32'hFFFF_F123, 1'b1, 32'h1234_5123, 3'b110},
    {7'd0,   32'h0000_0004, 1'b1, 32'h0000_1004, 3'b100},
    {7'd9,   32'h7ABC_D800, 1'b1, 32'hCAFE_0800, 3'b011},
    {7'd1,   32'h0001_2000, 1'b0, 32'h0000_0000, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [6:0] a, input logic [31:0] va);
    @(negedge clk);
    lk_valid = 1'b1; lk_asid = a; lk_vaddr = va;
    #2;
    p_hit = lk_hit; p_miss = lk_miss; p_stall = lk_stall; p_pa = lk_paddr; p_perm = lk_perm;
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [6:0] a, input logic [31:0] va,
                            input logic [31:0] pa);
    probe(a, va);
    chk(req, {30'd0, p_hit, p_miss}, 32'd2);
    chk(req, p_pa, pa);
  endtask

  task automatic expect_miss(input string req, input logic [6:0] a, input logic [31:0] va);
    probe(a, va);
    chk(req, {30'd0, p_hit, p_miss}, 32'd1);
  endtask

  task automatic fill(input logic [6:0] a, input logic [19:0] v, input logic [19:0] p,
                      input logic [2:0] pm);
    @(negedge clk);
    fill_valid = 1'b1; fill_asid = a; fill_vpn = v; fill_pfn = p; fill_perm = pm;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic flush(input logic [31:0] c);
    @(negedge clk);
    flush_wr = 1'b1; flush_cmd = c;
    @(posedge clk); #1;
    flush_wr = 1'b0;
  endtask

  task automatic set_cfg(input logic [31:0] c);
    @(negedge clk);
    cfg_word = c;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_word = 32'h2000_0008;
    lk_valid = 0; lk_asid = 0; lk_vaddr = 0;
    fill_valid = 0; fill_asid = 0; fill_vpn = 0; fill_pfn = 0; fill_perm = 0;
    flush_wr = 0; flush_cmd = 0;
    b_lk_valid = 0; b_lk_asid = 0; b_lk_vaddr = 0;
    b_fill_valid = 0; b_fill_asid = 0; b_fill_vpn = 0; b_fill_pfn = 0; b_fill_perm = 0;
    b_flush_wr = 0; b_flush_cmd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 req", {31'd0, fill_req_valid}, 32'd0);
    chk("R1 stall", {31'd0, lk_stall}, 32'd0);
    expect_miss("R1 lookup", 7'd1, 32'h0001_0000);

    // R2 table of translations and probes
    for (int i = 0; i < 6; i++) fill(FILLS[i][49:43], FILLS[i][42:23], FILLS[i][22:3], FILLS[i][2:0]);
    for (int i = 0; i < 8; i++) begin
      probe(LOOKS[i][74:68], LOOKS[i][67:36]);
      chk("R2 hit", {31'd0, p_hit}, {31'd0, LOOKS[i][35]});
      chk("R2 paddr", p_pa, LOOKS[i][34:3]);
      chk("R2 perm", {29'd0, p_perm}, {29'd0, LOOKS[i][2:0]});
    end

    // R3 request from the first missed table probe
    chk("R3 req valid", {31'd0, fill_req_valid}, 32'd1);
    chk("R3 req asid", {25'd0, fill_req_asid}, 32'd3);
    chk("R3 req vpn", {12'd0, fill_req_vpn}, 32'h10);
    // R4 stall without serve-during-miss
    set_cfg(32'h0000_0008);
    probe(7'd1, 32'h0001_0000);
    chk("R4 stall", {29'd0, p_stall, p_hit, p_miss}, 32'd4);
    fill(7'd3, 20'h00010, 20'h77777, 3'b111);
    @(negedge clk);
    chk("R3 req cleared", {31'd0, fill_req_valid}, 32'd0);
    expect_hit("R3 refill hit", 7'd3, 32'h0001_0034, 32'h7777_7034);

    // R5 serve during outstanding miss
    set_cfg(32'h2000_0008);
    expect_miss("R5 first miss", 7'd5, 32'h4000_0000);
    chk("R5 req vpn", {12'd0, fill_req_vpn}, 32'h40000);
    expect_hit("R5 hit under miss", 7'd1, 32'h0001_0000, 32'hA001_0000);
    expect_miss("R5 second miss", 7'd6, 32'h5000_0000);
    chk("R5 req kept vpn", {12'd0, fill_req_vpn}, 32'h40000);
    chk("R5 req kept asid", {25'd0, fill_req_asid}, 32'd5);
    fill(7'd5, 20'h40000, 20'h00400, 3'b100);

    // R8 lookup in the flush write cycle sees old contents
    @(negedge clk);
    flush_wr = 1'b1; flush_cmd = 32'h0; lk_valid = 1'b1; lk_asid = 7'd1; lk_vaddr = 32'h0001_0000;
    #2;
    chk("R8 same cycle hit", {31'd0, lk_hit}, 32'd1);
    @(posedge clk); #1;
    flush_wr = 1'b0; lk_valid = 1'b0;
    expect_miss("R8 after flush", 7'd1, 32'h0001_0000);
    expect_miss("R6 flush all", 7'd9, 32'h7ABC_D000);

    // R6 / R7 flush kinds
    fill(7'd3, 20'h12345, 20'h00100, 3'b001);
    fill(7'd3, 20'h12346, 20'h00101, 3'b001);
    fill(7'd3, 20'h12300, 20'h00102, 3'b001);
    fill(7'd4, 20'h12345, 20'h00103, 3'b001);
    fill(7'd3, 20'h50000, 20'h00104, 3'b001);
    flush(32'h8301_2347);
    expect_miss("R6 group hit line", 7'd3, 32'h1234_5000);
    expect_miss("R6 group hit line2", 7'd3, 32'h1234_6000);
    expect_hit("R6 group spares section peer", 7'd3, 32'h1230_0000, 32'h0010_2000);
    expect_hit("R7 qualifier spares other asid", 7'd4, 32'h1234_5000, 32'h0010_3000);
    flush(32'h0001_2002);
    expect_miss("R6 section", 7'd3, 32'h1230_0000);
    expect_miss("R7 unqualified section", 7'd4, 32'h1234_5000);
    expect_hit("R6 section spares", 7'd3, 32'h5000_0000, 32'h0010_4000);
    flush(32'h0005_0001);
    expect_hit("R6 reserved type", 7'd3, 32'h5000_0000, 32'h0010_4000);
    fill(7'd5, 20'h60000, 20'h00105, 3'b001);
    flush(32'h8300_0000);
    expect_miss("R7 asid flush", 7'd3, 32'h5000_0000);
    expect_hit("R7 asid flush spares", 7'd5, 32'h6000_0000, 32'h0010_5000);
    flush(32'h0);
    expect_miss("R6 all", 7'd5, 32'h6000_0000);

    // R10 first-invalid replacement
    set_cfg(32'h2000_0003);
    fill(7'd1, 20'h10, 20'h1, 3'b0);
    fill(7'd1, 20'h20, 20'h2, 3'b0);
    fill(7'd1, 20'h30, 20'h3, 3'b0);
    flush(32'h8100_0023);
    fill(7'd1, 20'h40, 20'h4, 3'b0);
    expect_hit("R10 hole filled keeps A", 7'd1, 32'h0001_0000, 32'h0000_1000);
    expect_hit("R10 D", 7'd1, 32'h0004_0000, 32'h0000_4000);
    expect_miss("R10 B gone", 7'd1, 32'h0002_0000);
    fill(7'd1, 20'h50, 20'h5, 3'b0);
    expect_miss("R10 fallback line0", 7'd1, 32'h0001_0000);
    expect_hit("R10 E", 7'd1, 32'h0005_0000, 32'h0000_5000);
    expect_hit("R10 C kept", 7'd1, 32'h0003_0000, 32'h0000_3000);

    // R11 round-robin replacement
    flush(32'h0);
    set_cfg(32'h3000_0003);
    fill(7'd1, 20'h10, 20'h1, 3'b0);
    fill(7'd1, 20'h20, 20'h2, 3'b0);
    fill(7'd1, 20'h30, 20'h3, 3'b0);
    flush(32'h8100_0023);
    fill(7'd1, 20'h40, 20'h4, 3'b0);
    expect_miss("R11 pointer overwrote A", 7'd1, 32'h0001_0000);
    expect_miss("R11 B flushed", 7'd1, 32'h0002_0000);
    expect_hit("R11 D", 7'd1, 32'h0004_0000, 32'h0000_4000);
    fill(7'd1, 20'h50, 20'h5, 3'b0);
    fill(7'd1, 20'h60, 20'h6, 3'b0);
    expect_miss("R11 wrap replaced C", 7'd1, 32'h0003_0000);
    expect_hit("R11 E", 7'd1, 32'h0005_0000, 32'h0000_5000);
    expect_hit("R11 F", 7'd1, 32'h0006_0000, 32'h0000_6000);

    // R12 duplicate fill overwrites
    flush(32'h0);
    set_cfg(32'h2000_0002);
    fill(7'd1, 20'h10, 20'h1, 3'b0);
    fill(7'd1, 20'h10, 20'h2, 3'b0);
    fill(7'd1, 20'h20, 20'h3, 3'b0);
    expect_hit("R12 updated frame", 7'd1, 32'h0001_0000, 32'h0000_2000);
    fill(7'd1, 20'h30, 20'h4, 3'b0);
    expect_hit("R12 B kept", 7'd1, 32'h0002_0000, 32'h0000_3000);
    expect_hit("R12 C", 7'd1, 32'h0003_0000, 32'h0000_4000);

    // R9 active-line count
    flush(32'h0);
    set_cfg(32'h2000_0003);
    fill(7'd1, 20'h10, 20'h1, 3'b0);
    fill(7'd1, 20'h20, 20'h2, 3'b0);
    fill(7'd1, 20'h30, 20'h3, 3'b0);
    set_cfg(32'h2000_0001);
    expect_miss("R9 line1 inactive", 7'd1, 32'h0002_0000);
    expect_miss("R9 line2 inactive", 7'd1, 32'h0003_0000);
    expect_hit("R9 line0 active", 7'd1, 32'h0001_0000, 32'h0000_1000);
    set_cfg(32'h2000_0003);
    expect_miss("R9 cleared on regrow", 7'd1, 32'h0002_0000);
    set_cfg(32'h2000_0000);
    fill(7'd1, 20'h99, 20'h9, 3'b0);
    expect_miss("R9 zero lines", 7'd1, 32'h0009_9000);
    set_cfg(32'h2000_000F);
    flush(32'h0);
    for (int i = 0; i < 9; i++) fill(7'd2, 20'(i + 1), 20'(i + 16), 3'b0);
    expect_miss("R9 clamp evicts first", 7'd2, 32'h0000_1000);
    expect_hit("R9 clamp keeps second", 7'd2, 32'h0000_2000, 32'h0001_1000);
    expect_hit("R9 clamp ninth", 7'd2, 32'h0000_9000, 32'h0001_8000);

    // R7 narrow identifier field at [30:29]
    @(negedge clk);
    b_fill_valid = 1'b1; b_fill_asid = 2'd1; b_fill_vpn = 20'h100; b_fill_pfn = 20'h1; b_fill_perm = 3'b0;
    @(negedge clk);
    b_fill_asid = 2'd2; b_fill_pfn = 20'h2;
    @(negedge clk);
    b_fill_valid = 1'b0; b_flush_wr = 1'b1; b_flush_cmd = 32'hA200_0000;
    @(negedge clk);
    b_flush_wr = 1'b0; b_lk_valid = 1'b1; b_lk_asid = 2'd1; b_lk_vaddr = 32'h0010_0000;
    #2;
    chk("R7 narrow field flushed", {30'd0, b_lk_hit, b_lk_miss}, 32'd1);
    @(negedge clk);
    b_lk_asid = 2'd2;
    #2;
    chk("R7 narrow field spared", {30'd0, b_lk_hit, b_lk_miss}, 32'd2);
    chk("R7 narrow paddr", b_lk_paddr, 32'h0000_2000);
    @(negedge clk);
    b_lk_valid = 1'b0;

    summary();
    $finish;
  end
endmodule